// File: doc/BRIEF.md
# I2C Register-File Slave Controller

This block is a serial-bus slave that gives byte-wide access to a small register space through a generic register port. It sees both bus lines through synchronizers and a glitch filter. It finds START, repeated START and STOP, and answers only to one fixed 7-bit device address. A write transfer first loads an internal word pointer and then stores each following byte at the pointed register. A read transfer shifts out the pointed register, most significant bit first. The pointer steps by one on each acknowledge clock, so long transfers walk through consecutive registers. A read that does not load the pointer first starts from wherever the pointer was left.

The block also drives side-band signals for neighbouring timekeeping logic. A strobe marks each write to a clock register (addresses below 08h). A level flag stays high while a read is in progress on a clock register, so that logic can hold back its update. A strobe marks each fetch of the flags register at address 0Fh. A busy level tracks the bus between START and STOP.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1101000 binary. The lowest bit selects the direction: 0 means write and 1 means read. For any other address it leaves SDA released and ignores the bus until the next START.
- R2: START (SDA falls while SCL is high) raises `bus_busy`. STOP (SDA rises while SCL is high) lowers it. A STOP also returns the block to idle with SDA released.
- R3: The block pulls SDA low through the ninth clock after a matching address byte, after the word-address byte and after every data byte it receives.
- R4: In a write transfer, the low four bits of the first byte after the address load the pointer. Each later byte comes out on `reg_wdata`, with `reg_we` high for one cycle and `reg_addr` equal to the pointer. The pointer then steps by one on that byte's acknowledge clock.
- R5: The pointer is four bits wide and steps from 0Fh to 00h, for both writes and reads.
- R6: In a read transfer, the register at the pointer is sent MSB first. A master ACK steps the pointer and fetches the next register. A master NACK leaves the pointer unchanged and keeps SDA released until the next START or STOP.
- R7: A read with no pointer load in the same transfer starts at the pointer value left by the previous transfer.
- R8: `clk_wr_stb` pulses for one cycle together with `reg_we`, and only when the write address is below 08h.
- R9: `clk_rd_freeze` goes high when a byte at an address below 08h is fetched for a read. It goes low on STOP, or when a byte at 08h or above is fetched.
- R10: `flags_rd_stb` pulses for one cycle each time the byte at address 0Fh is fetched for a read.
- R11: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks has no effect. In particular, a short low glitch on SDA while SCL is high is not taken as a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| bus_busy | output | 1 | High between START and STOP |
| reg_addr | output | 4 | Current pointer, address of the register port |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, sampled when a byte is fetched |
| clk_wr_stb | output | 1 | Write strobe for clock registers (address < 08h) |
| clk_rd_freeze | output | 1 | High while a clock-register read is in progress |
| flags_rd_stb | output | 1 | One-cycle strobe when address 0Fh is fetched |

## Verification
Each line edge reaches the controller 2 synchronizer cycles plus `FILT_CYCLES` filter cycles plus one edge-detect cycle after it happens at the pins, which is 15 cycles by default. Every result is then one register later. A write appears on the register port about 16 cycles after the eighth SCL fall of its byte. An acknowledge or data bit appears on `sda_oe` about 16 cycles after the SCL fall that precedes it. The bench runs SCL with 60-cycle half periods and samples SDA in the middle of each high phase, well after the drive has settled. Register writes are not timed by the bench: they go into a scoreboard queue and are matched whenever `reg_we` fires. Strobe counts and the freeze level are checked only while SCL is low, well after the fetch that sets them.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_DEV, PH_DEV_ACK, PH_PTR, PH_PTR_ACK,
    PH_WR, PH_WR_ACK, PH_RD, PH_RD_ACK
  } phase_t;
  localparam logic [6:0] DEV_ADDR_DEF = 7'b1101000;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int FILT_CYCLES = 12,
  parameter bit INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic pin_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{INIT}};
      run_q  <= '0;
      pin_o  <= INIT;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == pin_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYCLES - 1)) begin
        pin_o <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise = scl & ~scl_q;
    scl_fall = ~scl & scl_q;
    ev_start = scl & scl_q & sda_q & ~sda;
    ev_stop  = scl & scl_q & ~sda_q & sda;
  end
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int         AW         = 4,
  parameter int         DW         = 8,
  parameter int         CLK_REGION = 8,
  parameter int         FLAG_ADDR  = 15,
  parameter logic [6:0] DEV_ADDR   = DEV_ADDR_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic          busy,
  output logic [AW-1:0] ptr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          clk_wr_stb,
  output logic          freeze,
  output logic          flags_stb
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] FULL = BCW'(DW);

  phase_t         ph;
  logic [BCW-1:0] nbit;
  logic [DW-1:0]  rx_sh, tx_sh;
  logic           rd_dir, m_ack;
  logic           fetch;

  assign fetch = scl_fall && ((ph == PH_DEV_ACK && rd_dir) || (ph == PH_RD_ACK && m_ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; nbit <= '0; rx_sh <= '0; tx_sh <= '0;
      rd_dir <= 1'b0; m_ack <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
      busy <= 1'b0; we <= 1'b0; wdata <= '0; clk_wr_stb <= 1'b0;
      freeze <= 1'b0; flags_stb <= 1'b0;
    end else begin
      we <= 1'b0;
      clk_wr_stb <= 1'b0;
      flags_stb <= 1'b0;
      if (ev_stop) begin
        ph <= PH_IDLE; sda_oe <= 1'b0; busy <= 1'b0; freeze <= 1'b0; nbit <= '0;
      end else if (ev_start) begin
        ph <= PH_DEV; sda_oe <= 1'b0; busy <= 1'b1; nbit <= '0;
      end else begin
        if (scl_rise) begin
          unique case (ph)
            PH_DEV, PH_PTR, PH_WR: begin
              rx_sh <= {rx_sh[DW-2:0], sda};
              nbit  <= nbit + 1'b1;
            end
            PH_RD:     nbit <= nbit + 1'b1;
            PH_WR_ACK: ptr <= ptr + 1'b1;
            PH_RD_ACK: begin
              m_ack <= ~sda;
              if (!sda) ptr <= ptr + 1'b1;
            end
            default: ;
          endcase
        end
        if (scl_fall) begin
          unique case (ph)
            PH_DEV: if (nbit == FULL) begin
              nbit <= '0;
              if (rx_sh[DW-1:1] == DEV_ADDR) begin
                rd_dir <= rx_sh[0];
                sda_oe <= 1'b1;
                ph     <= PH_DEV_ACK;
              end else begin
                ph <= PH_IDLE;
              end
            end
            PH_DEV_ACK: if (!rd_dir) begin
              sda_oe <= 1'b0;
              ph     <= PH_PTR;
            end
            PH_PTR: if (nbit == FULL) begin
              ptr    <= rx_sh[AW-1:0];
              nbit   <= '0;
              sda_oe <= 1'b1;
              ph     <= PH_PTR_ACK;
            end
            PH_WR: if (nbit == FULL) begin
              we         <= 1'b1;
              wdata      <= rx_sh;
              clk_wr_stb <= (int'(ptr) < CLK_REGION);
              nbit       <= '0;
              sda_oe     <= 1'b1;
              ph         <= PH_WR_ACK;
            end
            PH_PTR_ACK, PH_WR_ACK: begin
              sda_oe <= 1'b0;
              ph     <= PH_WR;
            end
            PH_RD: begin
              if (nbit == FULL) begin
                sda_oe <= 1'b0;
                nbit   <= '0;
                ph     <= PH_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[DW-2];
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              end
            end
            PH_RD_ACK: if (!m_ack) begin
              sda_oe <= 1'b0;
              ph     <= PH_IDLE;
            end
            default: ;
          endcase
        end
        if (fetch) begin
          tx_sh     <= rdata;
          sda_oe    <= ~rdata[DW-1];
          nbit      <= '0;
          ph        <= PH_RD;
          freeze    <= (int'(ptr) < CLK_REGION);
          flags_stb <= (int'(ptr) == FLAG_ADDR);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         DW          = 8,
  parameter int         FILT_CYCLES = 12,
  parameter int         CLK_REGION  = 8,
  parameter int         FLAG_ADDR   = 15,
  parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          bus_busy,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          clk_wr_stb,
  output logic          clk_rd_freeze,
  output logic          flags_rd_stb
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw_l, clean_l;
  logic scl_rise, scl_fall, ev_start, ev_stop;

  assign raw_l = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_pin_filter #(.FILT_CYCLES(FILT_CYCLES), .INIT(1'b1)) u_filt (
      .clk(clk), .rst(rst), .pin_i(raw_l[g]), .pin_o(clean_l[g])
    );
  end

  i2c_bus_events u_ev (
    .clk(clk), .rst(rst), .scl(clean_l[0]), .sda(clean_l[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_rf_engine #(
    .AW(AW), .DW(DW), .CLK_REGION(CLK_REGION),
    .FLAG_ADDR(FLAG_ADDR), .DEV_ADDR(DEV_ADDR)
  ) u_eng (
    .clk(clk), .rst(rst), .sda(clean_l[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .rdata(reg_rdata), .sda_oe(sda_oe), .busy(bus_busy),
    .ptr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .clk_wr_stb(clk_wr_stb), .freeze(clk_rd_freeze), .flags_stb(flags_rd_stb)
  );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          bus_busy,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic          clk_wr_stb,
  input logic          clk_rd_freeze,
  input logic          flags_rd_stb
);
  // R2: outside a transfer the data line is never pulled low
  a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
    !bus_busy |-> !sda_oe);
  // R4: one write strobe per byte, address steady while it is presented
  a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $stable(reg_addr));
  // R8: clock-register strobe is a single-cycle pulse tied to a write
  a_r8_clk_strobe: assert property (@(posedge clk) disable iff (rst)
    clk_wr_stb |-> reg_we ##1 !clk_wr_stb);
  // R9: freeze never outlives the transfer
  a_r9_freeze_in_xfer: assert property (@(posedge clk) disable iff (rst)
    clk_rd_freeze |-> bus_busy);
  // R10: flags-read strobe is a single-cycle pulse
  a_r10_flags_pulse: assert property (@(posedge clk) disable iff (rst)
    flags_rd_stb |=> !flags_rd_stb);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .bus_busy(bus_busy),
  .reg_addr(reg_addr), .reg_we(reg_we), .clk_wr_stb(clk_wr_stb),
  .clk_rd_freeze(clk_rd_freeze), .flags_rd_stb(flags_rd_stb)
);

// File: tb/i2c_regfile_slave_tb.sv
`timescale 1ns/1ps
module i2c_regfile_slave_tb;
  localparam int HALF = 60;
  localparam int QTR  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, bus_busy, reg_we, clk_wr_stb, clk_rd_freeze, flags_rd_stb;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  wire sda_line = sda_m & ~sda_oe;

  assign reg_rdata = mem[reg_addr];

  i2c_regfile_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .bus_busy(bus_busy), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_wr_stb(clk_wr_stb), .clk_rd_freeze(clk_rd_freeze),
    .flags_rd_stb(flags_rd_stb)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, cws_cnt = 0, flg_cnt = 0;
  typedef struct packed { logic [3:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor / scoreboard, sampled on the falling clock edge
  always @(negedge clk) begin
    if (!rst) begin
      if (flags_rd_stb) flg_cnt++;
      if (clk_wr_stb) cws_cnt++;
      if (reg_we) begin
        wr_cnt++;
        mem[reg_addr] = reg_wdata;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected write at", int'(reg_addr), 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(reg_addr == e.a, "R4", "write address", int'(reg_addr), int'(e.a));
          chk(reg_wdata == e.d, "R4", "write data", int'(reg_wdata), int'(e.d));
          chk(clk_wr_stb == (reg_addr < 4'h8), "R8", "clock write strobe",
              int'(clk_wr_stb), int'(reg_addr < 4'h8));
        end
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HALF);
      scl_m = 1'b1; wt(HALF);
      scl_m = 1'b0; wt(QTR);
    end
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF / 2);
    acked = ~sda_line;
    wt(HALF / 2);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF);
      scl_m = 1'b1; wt(HALF / 2);
      b[i] = sda_line;
      wt(HALF / 2);
      scl_m = 1'b0; wt(QTR);
    end
    sda_m = ~give_ack; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    scl_m = 1'b0; wt(QTR);
    sda_m = 1'b1;
  endtask

  task automatic put_byte(input logic [7:0] b, input string req);
    logic ak;
    send_byte(b, ak);
    chk(ak == 1'b1, req, "slave acknowledge", int'(ak), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    logic ak;
    int c0, f0, w0;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
    wt(5);
    rst = 1'b0;
    wt(5);
    chk(sda_oe == 1'b0, "R2", "reset sda_oe", int'(sda_oe), 0);
    chk(bus_busy == 1'b0, "R2", "reset busy", int'(bus_busy), 0);
    chk(clk_rd_freeze == 1'b0, "R9", "reset freeze", int'(clk_rd_freeze), 0);

    // write E,F then wrap to 0 (R4, R5, R8)
    c0 = cws_cnt;
    exp_q.push_back('{4'hE, 8'h5A});
    exp_q.push_back('{4'hF, 8'hA5});
    exp_q.push_back('{4'h0, 8'h3C});
    bus_start();
    chk(bus_busy == 1'b1, "R2", "busy after START", int'(bus_busy), 1);
    put_byte(8'hD0, "R3");
    put_byte(8'h0E, "R3");
    put_byte(8'h5A, "R3");
    put_byte(8'hA5, "R5");
    put_byte(8'h3C, "R5");
    bus_stop();
    chk(bus_busy == 1'b0, "R2", "busy after STOP", int'(bus_busy), 0);
    chk(cws_cnt - c0 == 1, "R8", "clock write strobes", cws_cnt - c0, 1);

    // read without pointer load resumes at 01h (R7, R9)
    f0 = flg_cnt;
    bus_start();
    put_byte(8'hD1, "R1");
    recv_byte(1'b0, rb);
    chk(rb == 8'(1 * 17 + 3), "R7", "read from kept pointer", int'(rb), 1 * 17 + 3);
    chk(sda_oe == 1'b0, "R6", "released after NACK", int'(sda_oe), 0);
    chk(clk_rd_freeze == 1'b1, "R9", "freeze during clock read", int'(clk_rd_freeze), 1);
    bus_stop();
    chk(clk_rd_freeze == 1'b0, "R9", "freeze after STOP", int'(clk_rd_freeze), 0);
    chk(flg_cnt == f0, "R10", "no flags strobe", flg_cnt - f0, 0);

    // pointer load, repeated START, sequential read across wrap (R6, R5, R10, R9)
    bus_start();
    put_byte(8'hD0, "R3");
    put_byte(8'h0E, "R3");
    bus_start();
    put_byte(8'hD1, "R1");
    recv_byte(1'b1, rb);
    chk(rb == 8'h5A, "R6", "read byte at 0E", int'(rb), 'h5A);
    chk(clk_rd_freeze == 1'b0, "R9", "no freeze at 0E", int'(clk_rd_freeze), 0);
    recv_byte(1'b1, rb);
    chk(rb == 8'hA5, "R6", "read byte at 0F", int'(rb), 'hA5);
    chk(flg_cnt - f0 == 1, "R10", "flags strobe count", flg_cnt - f0, 1);
    recv_byte(1'b0, rb);
    chk(rb == 8'h3C, "R5", "read wraps to 00", int'(rb), 'h3C);
    chk(clk_rd_freeze == 1'b1, "R9", "freeze at 00", int'(clk_rd_freeze), 1);
    bus_stop();

    // foreign address is ignored (R1)
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA0, ak);
    chk(ak == 1'b0, "R1", "no ack to foreign address", int'(ak), 0);
    send_byte(8'h03, ak);
    chk(ak == 1'b0, "R1", "no ack to later byte", int'(ak), 0);
    send_byte(8'h77, ak);
    bus_stop();
    chk(wr_cnt == w0, "R1", "writes after foreign address", wr_cnt - w0, 0);

    // clock-register strobes only below 08h (R8)
    c0 = cws_cnt;
    exp_q.push_back('{4'h6, 8'h11});
    exp_q.push_back('{4'h7, 8'h22});
    exp_q.push_back('{4'h8, 8'h33});
    bus_start();
    put_byte(8'hD0, "R3");
    put_byte(8'h06, "R4");
    put_byte(8'h11, "R4");
    put_byte(8'h22, "R4");
    put_byte(8'h33, "R4");
    bus_stop();
    chk(cws_cnt - c0 == 2, "R8", "strobes at 06,07 only", cws_cnt - c0, 2);

    // short SDA glitch while SCL high is no START (R11)
    wt(HALF);
    sda_m = 1'b0; wt(5);
    sda_m = 1'b1; wt(3 * HALF);
    chk(bus_busy == 1'b0, "R11", "busy after glitch", int'(bus_busy), 0);

    chk(exp_q.size() == 0, "R4", "pending writes", exp_q.size(), 0);
    finish_run();
  end
endmodule